// File: doc/BRIEF.md
# Result Word Capture and Dual-Link Byte Sender

This block sits beside a processor's memory bus and waits for the program to store its final result. When a write reaches the result address, the block latches the 32-bit data word. It then hands the word, one byte at a time, to two serial link transmitters. Each transmitter takes bytes through a plain valid/ready byte port. The block does not model the link encoders, the line signalling or the link start-up sequence. Every byte goes to both links. The block moves on to the next byte only after both links have accepted the current one.

While a word is in flight the block holds a busy flag. When the last byte has been accepted, the block places the word on its result output, drops busy and raises a done strobe for exactly one cycle. It also gathers error signals from each link onto one flag bus. Parity errors and flow-control errors from a link are passed through a register. The disconnect (silence) timeout is computed here: each link has a counter that measures the time since the last transition on its lines. The counter limit comes from the clock frequency and the disconnect time given as parameters.

Top module: `result_sender`

## Requirements
- R1: While rst_n is low, busy, done, both link_valid bits, result_word and every err_flags bit are 0.
- R2: A cycle with bus_wr high and bus_addr equal to RESULT_ADDR (default 0x000000B8) while busy is low captures bus_wdata and sets busy from the next cycle. A write to any other address, or a cycle with bus_wr low, starts nothing.
- R3: The captured word leaves as four bytes on link_data, least significant byte first (0x00000C07 gives 0x07, 0x0C, 0x00, 0x00). Both links receive every byte. A byte transfers to link i on a cycle where link_valid[i] and link_ready[i] are both high.
- R4: link_data and link_valid[i] hold steady while link i has not yet accepted the current byte. Once a link has accepted, its valid drops and stays low until the other link has also accepted. The next byte appears only after both links have accepted.
- R5: On the clock edge where the last byte has been accepted by both links, busy falls, result_word takes the captured word and done is high for exactly one cycle. result_word changes at no other time.
- R6: A result-address write while busy is high is ignored. The word in flight and the later result_word are unchanged.
- R7: err_flags holds three bits per link i: bit 3*i is timeout, bit 3*i+1 is parity error and bit 3*i+2 is flow-control error. The parity and flow-control bits are the link's input error strobes delayed by one clock.
- R8: A link's timeout bit is high after TIMEOUT_CYC = ceil(DISCONNECT_NS*CLK_MHZ/1000) consecutive clock edges with no activity on that link (213 at the defaults). It is low after TIMEOUT_CYC-1 such edges. It clears one edge after activity is seen, and the other link's bit is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Processor bus write strobe |
| bus_addr | input | 32 | Processor bus address |
| bus_wdata | input | 32 | Processor bus write data |
| link_ready | input | 2 | Per-link byte accept |
| link_valid | output | 2 | Per-link byte offer |
| link_data | output | 8 | Byte offered to both links |
| link_activity | input | 2 | Per-link transition seen on data or strobe |
| link_parity_err | input | 2 | Per-link parity mismatch strobe |
| link_flow_err | input | 2 | Per-link flow-control error strobe |
| busy | output | 1 | Word transfer in progress |
| done | output | 1 | One-cycle strobe when the word has been sent |
| result_word | output | 32 | Last word fully sent |
| err_flags | output | 6 | Per-link error flags |

## Verification
The bench drives one link so that it accepts bytes more slowly than the other. This exposes a sequencer that advances on the first acceptance: the slow link would then miss bytes or get bytes out of order. A result-address write arrives in the middle of a transfer. A design that re-armed on it would change the bytes already being sent or the final result. Writes to a neighbouring address, and cycles with the address set but no write strobe, must leave busy low. The timeout is probed one edge before and one edge on its limit, which catches an off-by-one counter or a limit rounded down. The bench also checks that done lasts one cycle, so a strobe stuck high is caught.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  localparam int BYTE_W = 8;
  localparam int ERR_PER_LINK = 3;

  typedef enum logic [1:0] {
    ERR_TIMEOUT = 2'd0,
    ERR_PARITY  = 2'd1,
    ERR_FLOW    = 2'd2
  } err_slot_t;

  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction
endpackage

// File: rtl/rs_capture.sv
`timescale 1ns/1ps
module rs_capture #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] RESULT_ADDR = 32'h0000_00B8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              busy,
  output logic              start,
  output logic [DATA_W-1:0] cap_word
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(RESULT_ADDR);

  logic              hit;
  logic [DATA_W-1:0] cap_d;

  always_comb begin
    hit   = bus_wr && (bus_addr == MATCH);
    start = hit && !busy;
    cap_d = cap_word;
    if (start) cap_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_word <= '0;
    else        cap_word <= cap_d;
  end

  // R6: the latched word cannot move while a transfer is in flight
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cap_word));
  // R2: a matching write while idle always opens a transfer
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/rs_sequencer.sv
`timescale 1ns/1ps
module rs_sequencer
  import rs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LINKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DATA_W-1:0]    cap_word,
  input  logic [NUM_LINKS-1:0] tx_ready,
  output logic [NUM_LINKS-1:0] tx_valid,
  output logic [BYTE_W-1:0]    tx_data,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    result_word
);
  localparam int NUM_BYTES = DATA_W / BYTE_W;
  localparam int IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic                 busy_q, busy_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [NUM_LINKS-1:0] acked_q, acked_d;
  logic                 done_q, done_d;
  logic [DATA_W-1:0]    res_q, res_d;
  logic [NUM_LINKS-1:0] hs;
  logic                 all_taken;
  logic                 res_en;

  always_comb begin
    tx_valid  = {NUM_LINKS{busy_q}} & ~acked_q;
    tx_data   = cap_word[idx_q*BYTE_W +: BYTE_W];
    hs        = tx_valid & tx_ready;
    all_taken = &(acked_q | hs);

    busy_d  = busy_q;
    idx_d   = idx_q;
    acked_d = acked_q;
    done_d  = 1'b0;
    res_en  = 1'b0;

    if (start) begin
      busy_d  = 1'b1;
      idx_d   = '0;
      acked_d = '0;
    end else if (busy_q) begin
      if (all_taken) begin
        acked_d = '0;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          res_en = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        acked_d = acked_q | hs;
      end
    end
    res_d = res_en ? cap_word : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      acked_q <= '0;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      acked_q <= acked_d;
      done_q  <= done_d;
      res_q   <= res_d;
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign result_word = res_q;

  // R5: done is a single-cycle strobe that closes a transfer
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r5_result_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_word) |-> done);

  // R4: an unaccepted byte stays offered and unchanged
  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_hold
    a_r4_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[g] && !tx_ready[g]) |=> (tx_valid[g] && $stable(tx_data)));
  end
endmodule

// File: rtl/rs_link_monitor.sv
`timescale 1ns/1ps
module rs_link_monitor
  import rs_pkg::*;
#(
  parameter int TIMEOUT_CYC = 213
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    activity,
  input  logic                    parity_err,
  input  logic                    flow_err,
  output logic [ERR_PER_LINK-1:0] flags
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             par_q, flow_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = activity || (cnt_q != LIMIT);
    cnt_d  = cnt_q;
    if (cnt_en) cnt_d = activity ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      par_q  <= 1'b0;
      flow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      par_q  <= parity_err;
      flow_q <= flow_err;
    end
  end

  always_comb begin
    flags              = '0;
    flags[ERR_TIMEOUT] = (cnt_q == LIMIT);
    flags[ERR_PARITY]  = par_q;
    flags[ERR_FLOW]    = flow_q;
  end

  // R8: activity always clears the silence flag on the next edge
  a_r8_activity_clears: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !flags[ERR_TIMEOUT]);
  // R7: error strobes surface one clock later
  a_r7_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> flags[ERR_PARITY]);
  a_r7_flow_follows: assert property (@(posedge clk) disable iff (!rst_n)
    flow_err |=> flags[ERR_FLOW]);
endmodule

// File: rtl/result_sender.sv
`timescale 1ns/1ps
module result_sender
  import rs_pkg::*;
#(
  parameter int          ADDR_W        = 32,
  parameter int          DATA_W        = 32,
  parameter int          NUM_LINKS     = 2,
  parameter logic [31:0] RESULT_ADDR   = 32'h0000_00B8,
  parameter int          CLK_MHZ       = 250,
  parameter int          DISCONNECT_NS = 850
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [DATA_W-1:0]                 bus_wdata,
  input  logic [NUM_LINKS-1:0]              link_ready,
  output logic [NUM_LINKS-1:0]              link_valid,
  output logic [BYTE_W-1:0]                 link_data,
  input  logic [NUM_LINKS-1:0]              link_activity,
  input  logic [NUM_LINKS-1:0]              link_parity_err,
  input  logic [NUM_LINKS-1:0]              link_flow_err,
  output logic                              busy,
  output logic                              done,
  output logic [DATA_W-1:0]                 result_word,
  output logic [ERR_PER_LINK*NUM_LINKS-1:0] err_flags
);
  localparam int TIMEOUT_CYC = ns_to_cycles(DISCONNECT_NS, CLK_MHZ);

  logic              start;
  logic [DATA_W-1:0] cap_word;

  rs_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESULT_ADDR(RESULT_ADDR)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .start(start), .cap_word(cap_word)
  );

  rs_sequencer #(
    .DATA_W(DATA_W), .NUM_LINKS(NUM_LINKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_word(cap_word),
    .tx_ready(link_ready), .tx_valid(link_valid), .tx_data(link_data),
    .busy(busy), .done(done), .result_word(result_word)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    rs_link_monitor #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .clk(clk), .rst_n(rst_n),
      .activity(link_activity[i]),
      .parity_err(link_parity_err[i]),
      .flow_err(link_flow_err[i]),
      .flags(err_flags[ERR_PER_LINK*i +: ERR_PER_LINK])
    );
  end

  // R3: bytes are offered only inside a transfer
  a_r3_valid_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid != '0) |-> busy);
  // R2: a transfer never starts without a matching write
  a_r2_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_wr) && ($past(bus_addr) == ADDR_W'(RESULT_ADDR))));
endmodule

// File: tb/result_sender_tb.sv
`timescale 1ns/1ps
module result_sender_tb;
  localparam int LIMIT = (850 * 250 + 999) / 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  link_ready = 2'b11;
  logic [1:0]  link_valid;
  logic [7:0]  link_data;
  logic [1:0]  link_activity = 2'b11;
  logic [1:0]  link_parity_err = 2'b00;
  logic [1:0]  link_flow_err = 2'b00;
  logic        busy, done;
  logic [31:0] result_word;
  logic [5:0]  err_flags;

  int checks = 0;
  int errors = 0;
  int slow_mode = 0;
  int slow_cnt = 0;
  int split_seen = 0;
  logic [7:0] log0 [16];
  logic [7:0] log1 [16];
  int n0 = 0;
  int n1 = 0;

  always #2 clk = ~clk;

  result_sender u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .link_ready(link_ready), .link_valid(link_valid),
    .link_data(link_data), .link_activity(link_activity),
    .link_parity_err(link_parity_err), .link_flow_err(link_flow_err),
    .busy(busy), .done(done), .result_word(result_word), .err_flags(err_flags)
  );

  always @(posedge clk) begin
    #1;
    slow_cnt = slow_cnt + 1;
    if (slow_mode == 0) link_ready = 2'b11;
    else link_ready = {(slow_cnt % 3) == 0, 1'b1};
  end

  always @(negedge clk) begin
    if (link_valid[0] && link_ready[0] && n0 < 16) begin log0[n0] = link_data; n0 = n0 + 1; end
    if (link_valid[1] && link_ready[1] && n1 < 16) begin log1[n1] = link_data; n1 = n1 + 1; end
    if (link_valid == 2'b10) split_seen = split_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic check_bytes(input logic [31:0] w, input string req);
    chk(n0 == 4, req, n0, 4);
    chk(n1 == 4, req, n1, 4);
    for (int b = 0; b < 4; b++) begin
      chk(log0[b] == w[8*b +: 8], req, log0[b], w[8*b +: 8]);
      chk(log1[b] == w[8*b +: 8], req, log1[b], w[8*b +: 8]);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(link_valid == 2'b00, "R1 valid", link_valid, 0);
    chk(result_word == 32'h0, "R1 result", result_word, 0);
    chk(err_flags == 6'h0, "R1 err", err_flags, 0);
  endtask

  task automatic test_send(input logic [31:0] w, input int mode, input string tag);
    bit seen;
    slow_mode = mode; n0 = 0; n1 = 0; split_seen = 0;
    bus_write(32'h0000_00B8, w);
    chk(busy == 1'b1, "R2 busy after trigger", busy, 1);
    wait_done(seen);
    chk(seen, {tag, " R5 done seen"}, seen, 1);
    chk(busy == 1'b0, "R5 busy cleared", busy, 0);
    chk(result_word == w, "R5 result", result_word, w);
    @(negedge clk);
    chk(done == 1'b0, "R5 done one cycle", done, 0);
    check_bytes(w, {tag, " R3 bytes"});
    if (mode != 0) chk(split_seen > 0, "R4 link waits for peer", split_seen, 1);
    slow_mode = 0;
  endtask

  task automatic test_no_trigger();
    bus_write(32'h0000_00BC, 32'hDEAD_BEEF);
    repeat (3) begin
      @(negedge clk);
      chk(busy == 1'b0 && link_valid == 2'b00, "R2 other address ignored", {busy, link_valid}, 0);
    end
    @(posedge clk); #1;
    bus_addr = 32'h0000_00B8; bus_wdata = 32'h1111_2222;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R2 no strobe ignored", busy, 0);
  endtask

  task automatic test_busy_collision();
    bit seen;
    logic [31:0] a = 32'hA1B2_C3D4;
    slow_mode = 1; n0 = 0; n1 = 0;
    bus_write(32'h0000_00B8, a);
    repeat (2) @(posedge clk);
    bus_write(32'h0000_00B8, 32'h5566_7788);
    wait_done(seen);
    chk(seen, "R6 done seen", seen, 1);
    chk(result_word == a, "R6 result keeps first word", result_word, a);
    @(negedge clk);
    check_bytes(a, "R6 bytes");
    chk(busy == 1'b0, "R6 no re-arm", busy, 0);
    slow_mode = 0;
  endtask

  task automatic test_err_strobes();
    @(posedge clk); #1;
    link_parity_err = 2'b10;
    @(posedge clk); #1;
    link_parity_err = 2'b00;
    chk(err_flags == 6'b010000, "R7 link1 parity bit4", err_flags, 6'b010000);
    @(posedge clk); #1;
    chk(err_flags == 6'b000000, "R7 parity clears", err_flags, 0);
    link_flow_err = 2'b01;
    @(posedge clk); #1;
    link_flow_err = 2'b00;
    chk(err_flags == 6'b000100, "R7 link0 flow bit2", err_flags, 6'b000100);
  endtask

  task automatic test_timeout();
    @(posedge clk); #1;
    link_activity = 2'b10;
    repeat (LIMIT - 1) @(posedge clk);
    #1;
    chk(err_flags[0] == 1'b0, "R8 low before limit", err_flags[0], 0);
    @(posedge clk); #1;
    chk(err_flags[0] == 1'b1, "R8 high at limit", err_flags[0], 1);
    chk(err_flags[3] == 1'b0, "R8 other link untouched", err_flags[3], 0);
    link_activity = 2'b11;
    @(posedge clk); #1;
    chk(err_flags[0] == 1'b0, "R8 cleared by activity", err_flags[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    test_send(32'h0000_0C07, 0, "fast");
    test_send(32'h89AB_CDEF, 1, "slow");
    test_no_trigger();
    test_busy_collision();
    test_err_strobes();
    test_timeout();
    summary();
    $finish;
  end
endmodule